// File: doc/BRIEF.md
# Motor speed and shock status monitor

This block turns a measured spindle speed and a handful of servo fault lines into status flags. It compares the speed against a nominal reference and produces two start indications and one stop indication at fixed fractions of nominal speed. The stop threshold can be moved to a finer fraction with a configuration input.

A shock flag is formed from the lower start indication and five fault inputs: PLL lock, motor output saturation, FIFO overflow, servo interrupt and off-track detect. A sticky copy of the shock flag holds any occurrence until a clear pulse arrives.

A 4-bit select code routes one flag to a single status output. This output feeds a serial status read. Speed measurement, the servo loops and the FIFO are outside the block and arrive as inputs. Every output is registered, so each flag reflects the inputs sampled at the previous rising clock edge.

Top module: `motor_shock_status`

## Requirements
- R1: `start_hi_o` is high exactly when 4*speed >= 3*nominal (speed at or above 75% of nominal).
- R2: `start_lo_o` is high exactly when 2*speed >= nominal (speed at or above 50% of nominal). Whenever `start_hi_o` is high, `start_lo_o` is also high.
- R3: With `stop_fine_i` low, `stop_o` is high exactly when 100*speed <= 12*nominal.
- R4: With `stop_fine_i` high, `stop_o` is high exactly when 100*speed <= 6*nominal.
- R5: `shock_o` is the OR of the 50% start condition, `pll_lock_i`, `mot_sat_i`, `fifo_ovf_i`, `servo_irq_i` and `off_track_i`.
- R6: `shock_lat_o` goes high with any shock and stays high until a cycle in which `shock_clr_i` is high.
- R7: When `shock_clr_i` is high in the same cycle as a shock, the shock wins and `shock_lat_o` stays high. When `shock_clr_i` is high without a shock, `shock_lat_o` goes low.
- R8: `status_o` shows the flag picked by `sel_i` with this coding: 0 `subq_rdy_n_i`, 1 75% start, 2 50% start, 3 stop, 4 `pll_lock_i`, 5 `aux0_i`, 6 `aux1_i`, 7 `mot_sat_i`, 8 `fifo_ovf_i`, 9 shock, 10 latched shock.
- R9: Select codes 11 to 15 drive `status_o` low.
- R10: All outputs respond one clock after their inputs are sampled. While `rst_ni` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| speed_i | input | SPEED_W | Measured motor speed |
| nominal_i | input | SPEED_W | Nominal speed reference |
| stop_fine_i | input | 1 | 1 selects the 6% stop threshold, 0 selects 12% |
| pll_lock_i | input | 1 | PLL lock indication |
| mot_sat_i | input | 1 | Motor output stage saturated |
| fifo_ovf_i | input | 1 | FIFO overflow |
| servo_irq_i | input | 1 | Servo interrupt |
| off_track_i | input | 1 | Off-track detect |
| aux0_i | input | 1 | Pass-through input 0 |
| aux1_i | input | 1 | Pass-through input 1 |
| subq_rdy_n_i | input | 1 | Subcode ready, active low |
| shock_clr_i | input | 1 | Clears the latched shock flag |
| sel_i | input | 4 | Status select code |
| start_hi_o | output | 1 | Speed at or above 75% |
| start_lo_o | output | 1 | Speed at or above 50% |
| stop_o | output | 1 | Speed at or below the stop threshold |
| shock_o | output | 1 | Composite shock flag |
| shock_lat_o | output | 1 | Sticky shock flag |
| status_o | output | 1 | Selected status flag |

## Verification
The clear pulse and a new shock can land in the same cycle, and the two pull the sticky flag in opposite directions. The bench sweeps every speed and nominal pair of a 5-bit configuration at both stop settings. Across that sweep it raises fault lines in a rotating pattern and pulses the clear at an unrelated period, so the clear meets cycles both with and without a shock. A bench model of the sticky flag, in which a shock takes priority over a clear, judges every cycle. The select code also rotates through all sixteen values, which checks the routed flag and the zero codes in the same sweep.

// File: rtl/mss_pkg.sv
package mss_pkg;
  typedef enum logic [3:0] {
    SEL_SUBQ      = 4'd0,
    SEL_START_HI  = 4'd1,
    SEL_START_LO  = 4'd2,
    SEL_STOP      = 4'd3,
    SEL_PLL       = 4'd4,
    SEL_AUX0      = 4'd5,
    SEL_AUX1      = 4'd6,
    SEL_SAT       = 4'd7,
    SEL_FIFO      = 4'd8,
    SEL_SHOCK     = 4'd9,
    SEL_SHOCK_LAT = 4'd10
  } sel_e;

  localparam int unsigned NUM_SEL = 11;

  typedef struct packed {
    logic pll;
    logic sat;
    logic fifo;
    logic irq;
    logic otd;
  } fault_t;
endpackage

// File: rtl/mss_thresh.sv
module mss_thresh #(
  parameter int unsigned SPEED_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SPEED_W-1:0] speed_i,
  input  logic [SPEED_W-1:0] nominal_i,
  input  logic               stop_fine_i,
  output logic               start_hi_d_o,
  output logic               start_lo_d_o,
  output logic               stop_d_o,
  output logic               start_hi_o,
  output logic               start_lo_o,
  output logic               stop_o
);
  localparam int unsigned PW = SPEED_W + 6;
  localparam int unsigned NSTART = 2;
  // start thresholds as spd_k*speed >= nom_k*nominal
  localparam int unsigned SPD_K [NSTART] = '{4, 2};
  localparam int unsigned NOM_K [NSTART] = '{3, 1};

  logic [PW-1:0] spd_x, nom_x;
  logic [NSTART-1:0] start_d;

  assign spd_x = PW'(speed_i);
  assign nom_x = PW'(nominal_i);

  for (genvar g = 0; g < NSTART; g++) begin : g_start
    assign start_d[g] = (spd_x * PW'(SPD_K[g])) >= (nom_x * PW'(NOM_K[g]));
  end

  assign start_hi_d_o = start_d[0];
  assign start_lo_d_o = start_d[1];

  // 12%: 25*s <= 3*n ; 6%: 50*s <= 3*n
  logic [PW-1:0] stop_lhs;
  always_comb begin
    stop_lhs = stop_fine_i ? (spd_x * PW'(50)) : (spd_x * PW'(25));
  end
  assign stop_d_o = stop_lhs <= (nom_x * PW'(3));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_hi_o <= 1'b0;
      start_lo_o <= 1'b0;
      stop_o     <= 1'b0;
    end else begin
      start_hi_o <= start_hi_d_o;
      start_lo_o <= start_lo_d_o;
      stop_o     <= stop_d_o;
    end
  end

  p_start_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_hi_o |-> start_lo_o);

  p_stop_vs_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(nominal_i) != '0 && stop_o) |-> !start_lo_o);

  p_fine_tighter_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_fine_i && stop_d_o) |=> stop_o);
endmodule

// File: rtl/mss_shock.sv
module mss_shock
  import mss_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_lo_d_i,
  input  fault_t faults_i,
  input  logic   clr_i,
  output logic   shock_d_o,
  output logic   shock_lat_d_o,
  output logic   shock_o,
  output logic   shock_lat_o
);
  assign shock_d_o     = start_lo_d_i | (|faults_i);
  // a new shock outranks the clear
  assign shock_lat_d_o = shock_d_o | (shock_lat_o & ~clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shock_o     <= 1'b0;
      shock_lat_o <= 1'b0;
    end else begin
      shock_o     <= shock_d_o;
      shock_lat_o <= shock_lat_d_o;
    end
  end

  p_fault_shock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|faults_i) |=> shock_o);

  p_lat_follows_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shock_o |-> shock_lat_o);

  p_lat_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shock_lat_o && !clr_i) |=> shock_lat_o);

  p_clr_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !start_lo_d_i && !(|faults_i)) |=> !shock_lat_o);
endmodule

// File: rtl/mss_sel.sv
module mss_sel
  import mss_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [3:0]         sel_i,
  input  logic [NUM_SEL-1:0] flags_i,
  output logic               status_o
);
  logic status_d;

  always_comb begin
    status_d = 1'b0;
    if (32'(sel_i) < NUM_SEL) status_d = flags_i[sel_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_o <= 1'b0;
    else         status_o <= status_d;
  end

  p_unused_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(sel_i) >= NUM_SEL) |=> !status_o);

  p_route_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(sel_i) < NUM_SEL && flags_i[sel_i]) |=> status_o);
endmodule

// File: rtl/motor_shock_status.sv
module motor_shock_status
  import mss_pkg::*;
#(
  parameter int unsigned SPEED_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SPEED_W-1:0] speed_i,
  input  logic [SPEED_W-1:0] nominal_i,
  input  logic               stop_fine_i,
  input  logic               pll_lock_i,
  input  logic               mot_sat_i,
  input  logic               fifo_ovf_i,
  input  logic               servo_irq_i,
  input  logic               off_track_i,
  input  logic               aux0_i,
  input  logic               aux1_i,
  input  logic               subq_rdy_n_i,
  input  logic               shock_clr_i,
  input  logic [3:0]         sel_i,
  output logic               start_hi_o,
  output logic               start_lo_o,
  output logic               stop_o,
  output logic               shock_o,
  output logic               shock_lat_o,
  output logic               status_o
);
  logic start_hi_d, start_lo_d, stop_d, shock_d, shock_lat_d;
  fault_t faults;
  logic [NUM_SEL-1:0] flags;

  assign faults = '{pll: pll_lock_i, sat: mot_sat_i, fifo: fifo_ovf_i,
                    irq: servo_irq_i, otd: off_track_i};

  mss_thresh #(.SPEED_W(SPEED_W)) u_thresh (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .speed_i     (speed_i),
    .nominal_i   (nominal_i),
    .stop_fine_i (stop_fine_i),
    .start_hi_d_o(start_hi_d),
    .start_lo_d_o(start_lo_d),
    .stop_d_o    (stop_d),
    .start_hi_o  (start_hi_o),
    .start_lo_o  (start_lo_o),
    .stop_o      (stop_o)
  );

  mss_shock u_shock (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_lo_d_i (start_lo_d),
    .faults_i     (faults),
    .clr_i        (shock_clr_i),
    .shock_d_o    (shock_d),
    .shock_lat_d_o(shock_lat_d),
    .shock_o      (shock_o),
    .shock_lat_o  (shock_lat_o)
  );

  always_comb begin
    flags                = '0;
    flags[SEL_SUBQ]      = subq_rdy_n_i;
    flags[SEL_START_HI]  = start_hi_d;
    flags[SEL_START_LO]  = start_lo_d;
    flags[SEL_STOP]      = stop_d;
    flags[SEL_PLL]       = pll_lock_i;
    flags[SEL_AUX0]      = aux0_i;
    flags[SEL_AUX1]      = aux1_i;
    flags[SEL_SAT]       = mot_sat_i;
    flags[SEL_FIFO]      = fifo_ovf_i;
    flags[SEL_SHOCK]     = shock_d;
    flags[SEL_SHOCK_LAT] = shock_lat_d;
  end

  mss_sel u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .flags_i (flags),
    .status_o(status_o)
  );

  p_status_lat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 4'(SEL_SHOCK_LAT)) |=> (status_o == shock_lat_o));
endmodule

// File: tb/motor_shock_status_tb.sv
module motor_shock_status_tb;
  localparam int unsigned W = 5;
  localparam int unsigned N = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] speed = '0, nominal = '0;
  logic fine = 1'b0, pll = 1'b0, sat = 1'b0, fifo = 1'b0, irq = 1'b0, otd = 1'b0;
  logic aux0 = 1'b0, aux1 = 1'b0, subq_n = 1'b0, clr = 1'b0;
  logic [3:0] sel = '0;
  logic start_hi, start_lo, stop, shock, shock_lat, status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  motor_shock_status #(.SPEED_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .speed_i(speed), .nominal_i(nominal),
    .stop_fine_i(fine), .pll_lock_i(pll), .mot_sat_i(sat), .fifo_ovf_i(fifo),
    .servo_irq_i(irq), .off_track_i(otd), .aux0_i(aux0), .aux1_i(aux1),
    .subq_rdy_n_i(subq_n), .shock_clr_i(clr), .sel_i(sel),
    .start_hi_o(start_hi), .start_lo_o(start_lo), .stop_o(stop),
    .shock_o(shock), .shock_lat_o(shock_lat), .status_o(status)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic lat_exp;
    lat_exp = 1'b0;
    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10 start_hi", start_hi, 1'b0);
    chk("R10 start_lo", start_lo, 1'b0);
    chk("R10 stop", stop, 1'b0);
    chk("R10 shock", shock, 1'b0);
    chk("R10 shock_lat", shock_lat, 1'b0);
    chk("R10 status", status, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 2 * N * N; i++) begin
      int s, n, f;
      logic hi_e, lo_e, stop_e, shock_e, st_e, fault_any;
      logic [4:0] fv;
      s = i % N;
      n = (i / N) % N;
      f = i / (N * N);
      fv = (i % 6 == 0) ? 5'(1 << ((i / 6) % 5)) : 5'd0;
      if (i % 11 == 5) fv = 5'b10101;
      speed = W'(s);
      nominal = W'(n);
      fine = f[0];
      {pll, sat, fifo, irq, otd} = fv;
      aux0 = i[1];
      aux1 = i[2];
      subq_n = i[3];
      clr = (i % 9 == 4);
      sel = 4'(i % 16);

      hi_e = (100 * s >= 75 * n);
      lo_e = (100 * s >= 50 * n);
      stop_e = fine ? (100 * s <= 6 * n) : (100 * s <= 12 * n);
      fault_any = |fv;
      shock_e = lo_e | fault_any;
      lat_exp = shock_e | (lat_exp & ~clr);
      case (i % 16)
        0: st_e = subq_n;
        1: st_e = hi_e;
        2: st_e = lo_e;
        3: st_e = stop_e;
        4: st_e = pll;
        5: st_e = aux0;
        6: st_e = aux1;
        7: st_e = sat;
        8: st_e = fifo;
        9: st_e = shock_e;
        10: st_e = lat_exp;
        default: st_e = 1'b0;
      endcase

      @(negedge clk);
      chk("R1 start_hi", start_hi, hi_e);
      chk("R2 start_lo", start_lo, lo_e);
      if (f == 0) chk("R3 stop 12pct", stop, stop_e);
      else        chk("R4 stop 6pct", stop, stop_e);
      chk("R5 shock", shock, shock_e);
      if (clr) chk("R7 clear vs shock", shock_lat, lat_exp);
      else     chk("R6 sticky", shock_lat, lat_exp);
      if (i % 16 >= 11) chk("R9 unused sel", status, st_e);
      else              chk("R8 status mux", status, st_e);
    end

    // R7: directed collision of clear and shock, then clear alone
    speed = '0; nominal = W'(N - 1); fine = 1'b0;
    {pll, sat, fifo, irq, otd} = 5'b00001; clr = 1'b0; sel = 4'd10;
    @(negedge clk);
    chk("R6 set", shock_lat, 1'b1);
    clr = 1'b1;
    @(negedge clk);
    chk("R7 shock beats clear", shock_lat, 1'b1);
    otd = 1'b0;
    @(negedge clk);
    chk("R7 clear alone", shock_lat, 1'b0);
    chk("R8 status lat", status, 1'b0);
    clr = 1'b0;
    @(negedge clk);
    chk("R6 stays clear", shock_lat, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule